// File: doc/BRIEF.md
# Operand addressing mode decoder

This block examines the addressing fields of a 16-bit instruction and describes how each operand reaches its data. The instruction can have two operands or one. For each operand it reports the addressing kind, whether an extension word follows the opcode, and whether the operand is fetched through a register used as a pointer. It also reports whether that pointer register is advanced afterwards, and by how many bytes. It gives the total instruction length in words and the number of clock cycles the instruction takes. Register 0, the program counter, makes two more kinds available. Indexed mode on it means PC-relative (symbolic) addressing, and autoincrement on it means an immediate constant. Indexed mode on register 2 selects absolute addressing.

The control logic pulses `start` together with the decoded fields. The block captures its decode in that cycle and holds it. It then raises `busy` for exactly the number of cycles the instruction needs. A `start` that arrives while `busy` is high is ignored. Memory access, the register file and the ALU are outside this block.

Top module: `addr_mode_decoder`

## Requirements
- R1: The source kind is coded REG=0, IDX=1, SYM=2, ABS=3, IND=4, AINC=5, IMM=6. Source mode 00 gives REG and 10 gives IND. Mode 01 gives SYM on register 0, ABS on register 2 and IDX on any other register. Mode 11 gives IMM on register 0 and AINC on any other register. `src_ind` is 1 for IND, AINC and IMM.
- R2: On a two-operand instruction, destination mode 0 gives REG. Destination mode 1 gives SYM on register 0, ABS on register 2 and IDX otherwise. On a single-operand instruction (`fmt_single`=1), `dst_kind` is REG and `dst_ext` is 0.
- R3: `len_words` is 1, plus 1 when the source kind is IDX, SYM, ABS or IMM, plus 1 when the destination kind is IDX, SYM or ABS. The result is never above 3.
- R4: The cycle count of a two-operand instruction depends on the source mode, the destination mode and whether the destination is the PC. With a REG source: REG destination takes 1 cycle (2 if it is the PC) and a memory destination takes 4. With an IDX/SYM/ABS source: register destination takes 3 and memory destination takes 6. With an IND source: register destination takes 2 and memory destination takes 4. With an AINC/IMM source: register destination takes 2 (3 if it is the PC) and memory destination takes 5.
- R5: On a two-operand instruction, `dadd_op`=1 adds one cycle to the R4 value. On a single-operand instruction it has no effect.
- R6: On a single-operand instruction, `op_cls` is coded 0 = shift/swap/extend (3 is treated the same), 1 = push and 2 = call. The cycle count for source mode 00/01/10/11 is 1/4/3/3 for shift, 3/5/4/4 for push and 4/5/4/5 for call.
- R7: For AINC and IMM sources, `src_inc` is 1. `inc_step` is 1 for a byte operation and 2 for a word operation. A pointer that is register 0 or register 1 always steps by 2. When `src_inc` is 0, `inc_step` is 0.
- R8: A single-operand shift-class instruction with an IMM operand sets `illegal`=1, with `wb_en`=0 and `src_inc`=0. `wb_en` is 1 for every two-operand instruction and for legal shift-class instructions. It is 0 for push and call.
- R9: After a `start` accepted at a clock edge, the decode outputs show the new values and `busy` is 1 for exactly `cycles` consecutive cycles.
- R10: A `start` while `busy` is 1 is ignored. The outputs do not change and the busy period is not extended.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Present a new instruction |
| fmt_single | input | 1 | 1 = single-operand, 0 = two-operand |
| src_mode | input | 2 | Source mode field |
| dst_mode | input | 1 | Destination mode field |
| src_reg | input | 4 | Source register number |
| dst_reg | input | 4 | Destination register number |
| op_cls | input | 2 | Single-operand class |
| byte_op | input | 1 | Byte-sized operation |
| dadd_op | input | 1 | Decimal add operation |
| src_kind | output | 3 | Source addressing kind |
| dst_kind | output | 3 | Destination addressing kind |
| src_ext | output | 1 | Source needs an extension word |
| dst_ext | output | 1 | Destination needs an extension word |
| src_ind | output | 1 | Source read through a register pointer |
| src_inc | output | 1 | Pointer register is post-incremented |
| inc_step | output | 2 | Increment amount in bytes |
| illegal | output | 1 | Immediate kind in a written operand |
| wb_en | output | 1 | Operand is written back |
| len_words | output | 2 | Instruction length in words |
| cycles | output | 3 | Instruction cycle count |
| busy | output | 1 | Instruction in progress |

## Verification
The hardest state to reach is a second `start` that lands in the middle of a busy period. It must change neither the held decode nor the remaining count. The stimulus reaches it by starting a six-cycle instruction and then, one cycle later, pulsing `start` with an entirely different set of fields. The outputs are compared at once, and the monitor confirms that the busy run still lasts exactly six cycles. The other difficult cases are the register-0 and register-2 aliases and the PC-destination extra cycle. Each is reached by a vector that holds the mode fixed and changes only the register number.

// File: rtl/amd_pkg.sv
package amd_pkg;
    localparam int REG_W  = 4;
    localparam int CYC_W  = 3;
    localparam int LEN_W  = 2;
    localparam int STEP_W = 2;
    localparam logic [REG_W-1:0] PC_NUM  = REG_W'(0);
    localparam logic [REG_W-1:0] SP_NUM  = REG_W'(1);
    localparam logic [REG_W-1:0] ABS_NUM = REG_W'(2);

    typedef enum logic [2:0] {
        K_REG = 3'd0, K_IDX = 3'd1, K_SYM = 3'd2, K_ABS = 3'd3,
        K_IND = 3'd4, K_AINC = 3'd5, K_IMM = 3'd6
    } opnd_kind_e;

    typedef enum logic [1:0] {
        CL_SHIFT = 2'd0, CL_PUSH = 2'd1, CL_CALL = 2'd2, CL_RSVD = 2'd3
    } op_cls_e;

    typedef struct packed {
        opnd_kind_e         src_kind;
        opnd_kind_e         dst_kind;
        logic               src_ext;
        logic               dst_ext;
        logic               src_ind;
        logic               src_inc;
        logic [STEP_W-1:0]  inc_step;
        logic               illegal;
        logic               wb_en;
        logic [LEN_W-1:0]   len;
        logic [CYC_W-1:0]   cyc;
    } decode_t;

    function automatic opnd_kind_e src_kind_of(input logic [1:0] mode,
                                               input logic [REG_W-1:0] rn);
        unique case (mode)
            2'b00: return K_REG;
            2'b01: return (rn == PC_NUM) ? K_SYM : (rn == ABS_NUM) ? K_ABS : K_IDX;
            2'b10: return K_IND;
            default: return (rn == PC_NUM) ? K_IMM : K_AINC;
        endcase
    endfunction

    function automatic logic needs_ext(input opnd_kind_e k);
        return (k == K_IDX) || (k == K_SYM) || (k == K_ABS) || (k == K_IMM);
    endfunction
endpackage

// File: rtl/amd_opnd.sv
module amd_opnd
    import amd_pkg::*;
(
    input  logic              fmt_single,
    input  logic [1:0]        src_mode,
    input  logic              dst_mode,
    input  logic [REG_W-1:0]  src_reg,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [1:0]        op_cls,
    input  logic              byte_op,
    output opnd_kind_e        src_kind,
    output opnd_kind_e        dst_kind,
    output logic              src_ext,
    output logic              dst_ext,
    output logic              src_ind,
    output logic              src_inc,
    output logic [STEP_W-1:0] inc_step,
    output logic              illegal,
    output logic              wb_en
);
    logic shift_cls;
    logic wide_ptr;

    always_comb begin
        shift_cls = (op_cls == CL_SHIFT) || (op_cls == CL_RSVD);
        src_kind  = src_kind_of(src_mode, src_reg);
        if (fmt_single || !dst_mode)
            dst_kind = K_REG;
        else if (dst_reg == PC_NUM)
            dst_kind = K_SYM;
        else if (dst_reg == ABS_NUM)
            dst_kind = K_ABS;
        else
            dst_kind = K_IDX;

        src_ext  = needs_ext(src_kind);
        dst_ext  = needs_ext(dst_kind);
        src_ind  = (src_kind == K_IND) || (src_kind == K_AINC) || (src_kind == K_IMM);
        illegal  = fmt_single && shift_cls && (src_kind == K_IMM);
        src_inc  = ((src_kind == K_AINC) || (src_kind == K_IMM)) && !illegal;
        wide_ptr = (src_reg == PC_NUM) || (src_reg == SP_NUM);
        if (!src_inc)
            inc_step = '0;
        else if (byte_op && !wide_ptr)
            inc_step = STEP_W'(1);
        else
            inc_step = STEP_W'(2);
        wb_en = fmt_single ? (shift_cls && !illegal) : 1'b1;
    end
endmodule

// File: rtl/amd_cost.sv
module amd_cost
    import amd_pkg::*;
(
    input  logic              fmt_single,
    input  logic [1:0]        src_mode,
    input  logic              dst_mode,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [1:0]        op_cls,
    input  logic              dadd_op,
    input  logic              src_ext,
    input  logic              dst_ext,
    output logic [LEN_W-1:0]  len,
    output logic [CYC_W-1:0]  cyc
);
    logic              dst_pc;
    logic [CYC_W-1:0]  base;

    always_comb begin
        dst_pc = !dst_mode && (dst_reg == PC_NUM);
        base   = '0;
        if (!fmt_single) begin
            unique case (src_mode)
                2'b00: base = dst_mode ? CYC_W'(4) : (dst_pc ? CYC_W'(2) : CYC_W'(1));
                2'b01: base = dst_mode ? CYC_W'(6) : CYC_W'(3);
                2'b10: base = dst_mode ? CYC_W'(4) : CYC_W'(2);
                default: base = dst_mode ? CYC_W'(5) : (dst_pc ? CYC_W'(3) : CYC_W'(2));
            endcase
            cyc = base + CYC_W'(dadd_op);
        end else begin
            unique case (op_cls)
                CL_PUSH: unique case (src_mode)
                    2'b00: base = CYC_W'(3);
                    2'b01: base = CYC_W'(5);
                    default: base = CYC_W'(4);
                endcase
                CL_CALL: unique case (src_mode)
                    2'b00, 2'b10: base = CYC_W'(4);
                    default: base = CYC_W'(5);
                endcase
                default: unique case (src_mode)
                    2'b00: base = CYC_W'(1);
                    2'b01: base = CYC_W'(4);
                    default: base = CYC_W'(3);
                endcase
            endcase
            cyc = base;
        end
        len = LEN_W'(1) + LEN_W'(src_ext) + LEN_W'(dst_ext);
    end
endmodule

// File: rtl/amd_seq.sv
module amd_seq
    import amd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  decode_t dec_in,
    output decode_t dec_q,
    output logic    busy
);
    logic [CYC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
            busy  <= 1'b0;
            cnt   <= '0;
        end else if (start && !busy) begin
            dec_q <= dec_in;
            busy  <= 1'b1;
            cnt   <= dec_in.cyc - CYC_W'(1);
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - CYC_W'(1);
        end
    end

    // R9
    load_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == $past(dec_in.cyc) - CYC_W'(1)));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(cnt) == '0));

    // R10
    hold_dec_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> $stable(dec_q));

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (dec_q.len >= LEN_W'(1) && dec_q.len <= LEN_W'(3)));

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && dec_q.illegal) |-> (!dec_q.src_inc && !dec_q.wb_en));
endmodule

// File: rtl/addr_mode_decoder.sv
module addr_mode_decoder
    import amd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fmt_single,
    input  logic [1:0]        src_mode,
    input  logic              dst_mode,
    input  logic [REG_W-1:0]  src_reg,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [1:0]        op_cls,
    input  logic              byte_op,
    input  logic              dadd_op,
    output logic [2:0]        src_kind,
    output logic [2:0]        dst_kind,
    output logic              src_ext,
    output logic              dst_ext,
    output logic              src_ind,
    output logic              src_inc,
    output logic [STEP_W-1:0] inc_step,
    output logic              illegal,
    output logic              wb_en,
    output logic [LEN_W-1:0]  len_words,
    output logic [CYC_W-1:0]  cycles,
    output logic              busy
);
    decode_t dec_c;
    decode_t dec_q;

    amd_opnd u_opnd (
        .fmt_single (fmt_single),
        .src_mode   (src_mode),
        .dst_mode   (dst_mode),
        .src_reg    (src_reg),
        .dst_reg    (dst_reg),
        .op_cls     (op_cls),
        .byte_op    (byte_op),
        .src_kind   (dec_c.src_kind),
        .dst_kind   (dec_c.dst_kind),
        .src_ext    (dec_c.src_ext),
        .dst_ext    (dec_c.dst_ext),
        .src_ind    (dec_c.src_ind),
        .src_inc    (dec_c.src_inc),
        .inc_step   (dec_c.inc_step),
        .illegal    (dec_c.illegal),
        .wb_en      (dec_c.wb_en)
    );

    amd_cost u_cost (
        .fmt_single (fmt_single),
        .src_mode   (src_mode),
        .dst_mode   (dst_mode),
        .dst_reg    (dst_reg),
        .op_cls     (op_cls),
        .dadd_op    (dadd_op),
        .src_ext    (dec_c.src_ext),
        .dst_ext    (dec_c.dst_ext),
        .len        (dec_c.len),
        .cyc        (dec_c.cyc)
    );

    amd_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .dec_in (dec_c),
        .dec_q  (dec_q),
        .busy   (busy)
    );

    assign src_kind  = dec_q.src_kind;
    assign dst_kind  = dec_q.dst_kind;
    assign src_ext   = dec_q.src_ext;
    assign dst_ext   = dec_q.dst_ext;
    assign src_ind   = dec_q.src_ind;
    assign src_inc   = dec_q.src_inc;
    assign inc_step  = dec_q.inc_step;
    assign illegal   = dec_q.illegal;
    assign wb_en     = dec_q.wb_en;
    assign len_words = dec_q.len;
    assign cycles    = dec_q.cyc;
endmodule

// File: tb/sim_addr_mode_decoder.sv
module sim_addr_mode_decoder;
    typedef struct packed {
        logic [2:0] sk;
        logic [2:0] dk;
        logic       se;
        logic       de;
        logic       si;
        logic       sinc;
        logic [1:0] step;
        logic       ill;
        logic       wb;
        logic [1:0] len;
        logic [2:0] cyc;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic fmt_single = 1'b0;
    logic [1:0] src_mode = '0;
    logic dst_mode = 1'b0;
    logic [3:0] src_reg = '0;
    logic [3:0] dst_reg = '0;
    logic [1:0] op_cls = '0;
    logic byte_op = 1'b0;
    logic dadd_op = 1'b0;
    logic [2:0] src_kind, dst_kind;
    logic src_ext, dst_ext, src_ind, src_inc, illegal, wb_en, busy;
    logic [1:0] inc_step, len_words;
    logic [2:0] cycles;

    int n_chk = 0;
    int n_fail = 0;
    exp_t q[$];
    string tq[$];

    always #10 clk = ~clk;

    addr_mode_decoder u0 (
        .clk(clk), .rst(rst), .start(start), .fmt_single(fmt_single),
        .src_mode(src_mode), .dst_mode(dst_mode), .src_reg(src_reg),
        .dst_reg(dst_reg), .op_cls(op_cls), .byte_op(byte_op), .dadd_op(dadd_op),
        .src_kind(src_kind), .dst_kind(dst_kind), .src_ext(src_ext),
        .dst_ext(dst_ext), .src_ind(src_ind), .src_inc(src_inc),
        .inc_step(inc_step), .illegal(illegal), .wb_en(wb_en),
        .len_words(len_words), .cycles(cycles), .busy(busy)
    );

    function automatic exp_t actual();
        exp_t a;
        a = '{src_kind, dst_kind, src_ext, dst_ext, src_ind, src_inc,
              inc_step, illegal, wb_en, len_words, cycles};
        return a;
    endfunction

    function automatic logic [2:0] mem_kind(input logic [3:0] r);
        if (r == 4'd0) return 3'd2;
        if (r == 4'd2) return 3'd3;
        return 3'd1;
    endfunction

    function automatic exp_t model(input logic fs, input logic [1:0] s, input logic d,
                                   input logic [3:0] sr, input logic [3:0] dr,
                                   input logic [1:0] cls, input logic bop, input logic dd);
        exp_t e;
        int two_tab [4][2] = '{'{1,4}, '{3,6}, '{2,4}, '{2,5}};
        int sh_tab [4] = '{1,4,3,3};
        int pu_tab [4] = '{3,5,4,4};
        int ca_tab [4] = '{4,5,4,5};
        int c;
        logic shiftish;
        e = '0;
        case (s)
            2'd0: e.sk = 3'd0;
            2'd1: e.sk = mem_kind(sr);
            2'd2: e.sk = 3'd4;
            default: e.sk = (sr == 4'd0) ? 3'd6 : 3'd5;
        endcase
        e.dk = (!fs && d) ? mem_kind(dr) : 3'd0;
        e.se = (e.sk inside {3'd1, 3'd2, 3'd3, 3'd6});
        e.de = (e.dk != 3'd0);
        e.si = (e.sk >= 3'd4);
        shiftish = (cls == 2'd0) || (cls == 2'd3);
        e.ill = fs && shiftish && (e.sk == 3'd6);
        e.sinc = (e.sk >= 3'd5) && !e.ill;
        e.step = !e.sinc ? 2'd0 : (bop && sr > 4'd1) ? 2'd1 : 2'd2;
        e.wb = !fs || (shiftish && !e.ill);
        e.len = 2'd1 + 2'(e.se) + 2'(e.de);
        if (!fs) begin
            c = two_tab[s][d];
            if (!d && dr == 4'd0 && (s == 2'd0 || s == 2'd3)) c = c + 1;
            if (dd) c = c + 1;
        end else if (cls == 2'd1) c = pu_tab[s];
        else if (cls == 2'd2) c = ca_tab[s];
        else c = sh_tab[s];
        e.cyc = 3'(c);
        return e;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic issue(input logic fs, input logic [1:0] s, input logic d,
                         input logic [3:0] sr, input logic [3:0] dr, input logic [1:0] cls,
                         input logic bop, input logic dd, input string tag);
        while (busy || q.size() != 0) @(negedge clk);
        fmt_single = fs; src_mode = s; dst_mode = d; src_reg = sr; dst_reg = dr;
        op_cls = cls; byte_op = bop; dadd_op = dd;
        q.push_back(model(fs, s, d, sr, dr, cls, bop, dd));
        tq.push_back(tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: pops an expected item when busy rises, then measures the busy run (R9)
    initial begin : monitor
        logic pb;
        exp_t e;
        string t;
        int n;
        pb = 1'b0;
        forever begin
            @(negedge clk);
            if (busy && !pb && q.size() != 0) begin
                e = q.pop_front();
                t = tq.pop_front();
                check(actual() == e, t, 32'(actual()), 32'(e));
                n = 1;
                forever begin
                    @(negedge clk);
                    if (!busy) break;
                    n++;
                end
                check(n == int'(e.cyc), "R9 busy length", n, 32'(e.cyc));
            end
            pb = busy;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : driver
        exp_t held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(actual() == '0 && !busy, "R11 reset", 32'(actual()), 0);

        // two-operand, R1 R2 R3 R4
        issue(0, 2'd0, 0, 4'd5, 4'd8, 0, 0, 0, "R4 reg-reg");
        issue(0, 2'd0, 0, 4'd9, 4'd0, 0, 0, 0, "R4 reg-pc");
        issue(0, 2'd0, 1, 4'd5, 4'd6, 0, 0, 0, "R2 dst idx");
        issue(0, 2'd0, 1, 4'd8, 4'd0, 0, 0, 0, "R2 dst sym");
        issue(0, 2'd0, 1, 4'd5, 4'd2, 0, 0, 0, "R2 dst abs");
        issue(0, 2'd1, 0, 4'd5, 4'd7, 0, 0, 0, "R1 src idx");
        issue(0, 2'd1, 0, 4'd0, 4'd6, 0, 0, 0, "R1 src sym");
        issue(0, 2'd1, 0, 4'd2, 4'd6, 0, 0, 0, "R1 src abs");
        issue(0, 2'd1, 1, 4'd4, 4'd9, 0, 0, 0, "R3 len3");
        issue(0, 2'd2, 0, 4'd4, 4'd5, 0, 0, 0, "R1 src ind");
        issue(0, 2'd2, 0, 4'd4, 4'd0, 0, 0, 0, "R4 ind-pc");
        issue(0, 2'd2, 1, 4'd5, 4'd6, 0, 0, 0, "R4 ind-mem");
        issue(0, 2'd3, 0, 4'd5, 4'd6, 0, 1, 0, "R7 byte step");
        issue(0, 2'd3, 0, 4'd9, 4'd0, 0, 0, 0, "R4 ainc-pc");
        issue(0, 2'd3, 0, 4'd0, 4'd9, 0, 0, 0, "R1 src imm");
        issue(0, 2'd3, 1, 4'd0, 4'd0, 0, 0, 0, "R3 imm-sym");
        issue(0, 2'd3, 0, 4'd1, 4'd5, 0, 1, 0, "R7 sp step");
        issue(0, 2'd3, 0, 4'd0, 4'd5, 0, 1, 0, "R7 pc step");
        issue(0, 2'd0, 0, 4'd5, 4'd8, 0, 0, 1, "R5 dadd reg");
        issue(0, 2'd1, 1, 4'd5, 4'd8, 0, 0, 1, "R5 dadd mem");

        // single-operand, R6 R8
        issue(1, 2'd0, 1, 4'd5, 4'd0, 0, 0, 0, "R6 shift reg");
        issue(1, 2'd0, 0, 4'd5, 4'd0, 0, 0, 1, "R5 dadd ignored");
        issue(1, 2'd1, 0, 4'd7, 4'd0, 0, 0, 0, "R6 shift idx");
        issue(1, 2'd2, 0, 4'd9, 4'd0, 0, 0, 0, "R6 shift ind");
        issue(1, 2'd3, 0, 4'd10, 4'd0, 3, 0, 0, "R6 shift ainc");
        issue(1, 2'd3, 0, 4'd0, 4'd0, 0, 0, 0, "R8 illegal imm");
        issue(1, 2'd0, 0, 4'd5, 4'd0, 1, 0, 0, "R6 push reg");
        issue(1, 2'd1, 0, 4'd5, 4'd0, 1, 0, 0, "R6 push idx");
        issue(1, 2'd2, 0, 4'd5, 4'd0, 1, 0, 0, "R6 push ind");
        issue(1, 2'd3, 0, 4'd0, 4'd0, 1, 0, 0, "R6 push imm");
        issue(1, 2'd0, 0, 4'd5, 4'd0, 2, 0, 0, "R6 call reg");
        issue(1, 2'd1, 0, 4'd5, 4'd0, 2, 0, 0, "R6 call idx");
        issue(1, 2'd3, 0, 4'd0, 4'd0, 2, 1, 0, "R6 call imm");

        // R10: start during busy is ignored
        held = model(0, 2'd1, 1, 4'd4, 4'd9, 0, 0, 0);
        issue(0, 2'd1, 1, 4'd4, 4'd9, 0, 0, 0, "R10 base");
        fmt_single = 1; src_mode = 2'd0; dst_mode = 0; src_reg = 4'd3;
        op_cls = 2'd0; dadd_op = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(actual() == held && busy, "R10 held outputs", 32'(actual()), 32'(held));

        while (busy || q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule